// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a small synchronous state machine with a 3-bit state. On every clock it steps through a fixed loop of five codes that skips three of the eight binary values and does not follow binary order. The output is the state register itself, so downstream logic sees a clean, glitch-free code that changes only on the rising clock edge.

The three codes outside the loop get a defined successor, so they are never left open. Whatever value the flip-flops hold at power-up, the counter is back on the loop after at most one clock. The next-state function is written directly as D flip-flop inputs. A synchronous reset puts the counter on the first code of the loop. A test-only load port lets a bench or a scan-style test force any of the eight codes into the register, including the illegal ones, so that recovery can be shown.

Top module: `sq5_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the state becomes 000 on that edge. Reset takes priority over load and over counting.
- R2: With `rst` and `tst_load` low, each rising edge moves the state around the loop 000 → 010 → 011 → 101 → 110 → 000.
- R3: With `rst` and `tst_load` low, the unused code 001 is followed by 010.
- R4: With `rst` and `tst_load` low, the unused code 100 is followed by 101.
- R5: With `rst` and `tst_load` low, the unused code 111 is followed by 000.
- R6: With `rst` low and `tst_load` high, the rising edge stores `tst_code` into the state in place of the next code. Holding the load keeps that value.
- R7: From any of the eight codes, after one free-running edge the state is one of the five loop codes, and it then follows the R2 order without deviation.
- R8: `count` always equals the state register, and it changes only at rising edges of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to code 000 |
| tst_load | input | 1 | Test-only strobe that forces `tst_code` into the state |
| tst_code | input | 3 | Code to be forced when `tst_load` is high |
| count | output | 3 | Current state code |

## Verification
Every result is due one edge after its stimulus. A load, a reset, or a step of the loop shows on `count` right after the rising edge that samples it, because only one register lies between the inputs and the output. The bench drives inputs at falling edges and reads `count` at the next falling edge, which is half a period after the edge that updates the register. A load check therefore reads the forced code one falling edge after the strobe. The first free-running step from that code, which covers R3 to R5 and part of R2, is read one falling edge later. The loop is then tracked one code per falling edge.

// File: rtl/sq5_pkg.sv
package sq5_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned LOOP_LEN = 5;
  typedef logic [CODE_W-1:0] code_t;

  // Legal loop, in visiting order
  localparam code_t C_A = 3'b000;
  localparam code_t C_B = 3'b010;
  localparam code_t C_C = 3'b011;
  localparam code_t C_D = 3'b101;
  localparam code_t C_E = 3'b110;
  // Codes outside the loop
  localparam code_t X_1 = 3'b001;
  localparam code_t X_4 = 3'b100;
  localparam code_t X_7 = 3'b111;

  localparam code_t RESET_CODE = C_A;

  function automatic logic on_loop(code_t c);
    return (c == C_A) || (c == C_B) || (c == C_C) || (c == C_D) || (c == C_E);
  endfunction
endpackage

// File: rtl/sq5_next.sv
module sq5_next
  import sq5_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);
  // D inputs taken straight from the transition table, illegal codes included
  always_comb begin
    unique case (cur)
      C_A:     nxt = C_B;
      C_B:     nxt = C_C;
      C_C:     nxt = C_D;
      C_D:     nxt = C_E;
      C_E:     nxt = C_A;
      X_1:     nxt = C_B;
      X_4:     nxt = C_D;
      X_7:     nxt = C_A;
      default: nxt = RESET_CODE;
    endcase
  end
endmodule

// File: rtl/sq5_state_reg.sv
module sq5_state_reg
  import sq5_pkg::*;
#(
  parameter code_t INIT = RESET_CODE
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  force_en,
  input  code_t force_val,
  input  code_t d_next,
  output code_t q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= INIT;
    else if (force_en) q <= force_val;
    else               q <= d_next;
  end
endmodule

// File: rtl/sq5_counter.sv
module sq5_counter
  import sq5_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tst_load,
  input  logic [CODE_W-1:0] tst_code,
  output logic [CODE_W-1:0] count
);
  code_t state_q;
  code_t state_d;

  sq5_next u_next (
    .cur (state_q),
    .nxt (state_d)
  );

  sq5_state_reg #(.INIT(RESET_CODE)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .force_en  (tst_load),
    .force_val (tst_code),
    .d_next    (state_d),
    .q         (state_q)
  );

  assign count = state_q;

  // Becomes 1 after the first edge, so that $past never reads pre-clock values
  logic armed;
  always_ff @(posedge clk) armed <= 1'b1;

  p_reset_zero_r1: assert property (@(posedge clk)
    armed && $past(rst) |-> count == C_A);

  p_step_a_b_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!rst && !tst_load && count == C_A) |-> count == C_B);

  p_step_d_e_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!rst && !tst_load && count == C_D) |-> count == C_E);

  p_wrap_e_a_r2: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!rst && !tst_load && count == C_E) |-> count == C_A);

  p_fix_001_r3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!rst && !tst_load && count == X_1) |-> count == C_B);

  p_fix_100_r4: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!rst && !tst_load && count == X_4) |-> count == C_D);

  p_fix_111_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!rst && !tst_load && count == X_7) |-> count == C_A);

  p_force_r6: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!rst && tst_load) |-> count == $past(tst_code));

  p_on_loop_r7: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!rst && !tst_load) |-> on_loop(count));
endmodule

// File: tb/test_sq5_counter.sv
module test_sq5_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tst_load = 1'b0;
  logic [2:0] tst_code = 3'b000;
  logic [2:0] count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sq5_counter i_sq5_counter (
    .clk      (clk),
    .rst      (rst),
    .tst_load (tst_load),
    .tst_code (tst_code),
    .count    (count)
  );

  // Loop order from R2
  localparam logic [2:0] LOOP [5] = '{3'b000, 3'b010, 3'b011, 3'b101, 3'b110};
  // Vector table: preload code, expected code after one free edge, requirement
  localparam logic [2:0] START [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic [2:0] FIRST [8] = '{3'b010, 3'b010, 3'b011, 3'b101,
                                       3'b101, 3'b110, 3'b000, 3'b000};
  localparam string      TAG   [8] = '{"R2", "R3", "R2", "R2", "R4", "R2", "R2", "R5"};

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: count=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int loop_pos(input logic [2:0] c);
    for (int k = 0; k < 5; k++) if (LOOP[k] == c) return k;
    return -1;
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: count=%b expected=done", count);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pos;
    logic [2:0] held;
    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    check("R1", count, 3'b000);
    rst = 1'b0;

    // R2 / R8: two full turns of the loop from reset
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      check("R2", count, LOOP[n % 5]);
    end

    // Vector table: every code forced, then first step and five tracked steps
    for (int i = 0; i < 8; i++) begin
      tst_load = 1'b1;
      tst_code = START[i];
      @(negedge clk);
      tst_load = 1'b0;
      check("R6", count, START[i]);
      @(negedge clk);
      check(TAG[i], count, FIRST[i]);
      pos = loop_pos(FIRST[i]);
      if (pos < 0) check("R7", count, 3'b000);
      else begin
        for (int s = 0; s < 5; s++) begin
          @(negedge clk);
          pos = (pos + 1) % 5;
          check("R7", count, LOOP[pos]);
        end
      end
    end

    // R6: held load keeps the forced code
    tst_load = 1'b1;
    tst_code = 3'b100;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      check("R6", count, 3'b100);
    end
    tst_load = 1'b0;
    @(negedge clk);
    check("R4", count, 3'b101);

    // R1: reset mid-loop
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", count, 3'b000);

    // R1: reset wins over a simultaneous load
    tst_load = 1'b1;
    tst_code = 3'b111;
    @(negedge clk);
    check("R1", count, 3'b000);
    rst = 1'b0;
    tst_load = 1'b0;
    @(negedge clk);
    check("R2", count, 3'b010);

    // R8: output stable between rising edges
    held = count;
    #3;
    check("R8", count, held);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule